// File: doc/BRIEF.md
# Region-Gated Direct-Mapped Instruction Cache

This block is a read-only instruction cache placed between a processor fetch port and an external memory bus. It holds 256 direct-mapped lines of one 32-bit word each, 1 KB of data in all. Each line has a 32-bit tag word that carries a valid flag and the upper address bits. A fetch that hits returns its word one cycle after the request. A fetch that misses issues a single-word refill to memory. When the address lies in an enabled region, the returned word and a fresh tag are written into the line. In every case the word is handed back to the processor.

A five-bit control register decides which memory regions may be cached. Address bits 24:22 pick the region: values 0 to 3 select chip-select regions 0 to 3, and values 4 to 7 select the DRAM region. Only the lowest 32 MB of the address space can ever be cached. While every enable bit is clear, software can read and write the tag and data arrays as 2 KB of plain RAM through a word-addressed window. Software uses this window to preload lines and to invalidate them.

Top module: `icache_rgn`

## Requirements
- R1: After reset, the control register reads zero, `fetch_valid_o` and `mem_req_o` are low, and every line is invalid, so the first fetch to any enabled address misses.
- R2: The control register keeps only bits 4:0. Bits 15:5 always read zero, whatever value was written to them.
- R3: Address bits 24:22 select the region. Values 0..3 use enable bits 0..3 and values 4..7 use enable bit 4. A fetch in a region whose bit is clear always goes to memory, even if a matching valid line exists, and it does not fill the cache.
- R4: A fetch address above 0x01FFFFFF always goes to memory and never fills a line.
- R5: On a miss, `mem_req_o` rises one cycle after the request and holds `mem_addr_o` equal to the word-aligned fetch address until `mem_valid_i`. On the following cycle `fetch_valid_o` pulses with `fetch_data_o` equal to the memory word.
- R6: A fetch hits when three conditions hold: the line is valid (tag bit 25), tag bits 24:10 equal fetch address bits 24:10, and the region is enabled. A hit pulses `fetch_valid_o` with the stored word one cycle after the request, and no memory request is made.
- R7: A fetch to the same index (address bits 9:2) with a different tag misses and replaces the line, so the earlier address then misses.
- R8: With the control register at zero, window word addresses 0x000..0x0FF reach the tag words and 0x100..0x1FF reach the data words of lines 0..255. Writes store all 32 bits, and a read returns the word on `arr_rdata_o` one cycle after the request.
- R9: With any enable bit set, window writes are ignored and window reads return zero.
- R10: A refilled line's tag word reads as bit 25 set, bits 24:10 equal to the fetch address, and all other bits zero. Writing a tag word with bit 25 clear invalidates the line.
- R11: A line preloaded through the window, with bit 25 set and a matching tag, serves hits with the preloaded data once its region is enabled.
- R12: A fetch request made while a refill is outstanding is ignored. It causes no second response and does not disturb the memory address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, one cycle per fetch |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_valid_o | output | 1 | Fetch response strobe |
| fetch_data_o | output | 32 | Fetched instruction word |
| mem_req_o | output | 1 | Refill request, held until served |
| mem_addr_o | output | 32 | Word-aligned refill address |
| mem_valid_i | input | 1 | Refill word is present |
| mem_data_i | input | 32 | Refill word |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write value |
| cfg_rdata_o | output | 16 | Control register value |
| arr_req_i | input | 1 | Array window access strobe |
| arr_we_i | input | 1 | Array window write (1) or read (0) |
| arr_addr_i | input | 9 | Window word address; bit 8 selects data (1) or tag (0) |
| arr_wdata_i | input | 32 | Array window write word |
| arr_rdata_o | output | 32 | Array window read word |

## Verification
A hit answers on the first rising edge after the request. A miss raises `mem_req_o` on that same edge, and the response follows on the edge after `mem_valid_i` is sampled. Window reads appear one edge after the request, and control writes take effect at the edge where they are sampled. The bench drives every input on the falling edge and samples every output on the next falling edge, so each result is read half a cycle after the edge that makes it. For the stretched refill case, the bench also samples on each falling edge between request and grant, to confirm that nothing answers early.

// File: rtl/icache_rgn_pkg.sv
package icache_rgn_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned CACHE_AW  = 25;  // cacheable space is 2**CACHE_AW bytes
  localparam int unsigned VALID_BIT = CACHE_AW;
  localparam int unsigned RGN_LO    = 22;
  localparam int unsigned DRAM_BIT  = 4;
  localparam logic [CFG_W-1:0] CTRL_MASK = CFG_W'((1 << CTRL_W) - 1);

  typedef enum logic {ST_IDLE, ST_MISS} fetch_st_e;

  // region select from address bits 24:22
  function automatic logic [2:0] rgn_sel(input logic [2:0] hi);
    return hi[2] ? 3'(DRAM_BIT) : {1'b0, hi[1:0]};
  endfunction
endpackage

// File: rtl/icache_rgn_dec.sv
module icache_rgn_dec
  import icache_rgn_pkg::*;
(
  input  logic [ADDR_W-1:RGN_LO] addr_hi_i,
  input  logic [CTRL_W-1:0]      ctrl_i,
  output logic                   cacheable_o
);
  logic       in_range;
  logic [2:0] sel;

  assign in_range    = (addr_hi_i[ADDR_W-1:CACHE_AW] == '0);
  assign sel         = rgn_sel(addr_hi_i[CACHE_AW-1:RGN_LO]);
  assign cacheable_o = in_range && ctrl_i[sel];
endmodule

// File: rtl/icache_rgn_arrays.sv
module icache_rgn_arrays
  import icache_rgn_pkg::*;
#(
  parameter int unsigned LINES = 256,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  look_idx_i,
  output logic [WORD_W-1:0] look_tag_o,
  output logic [WORD_W-1:0] look_data_o,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [WORD_W-1:0] fill_tag_i,
  input  logic [WORD_W-1:0] fill_data_i,
  input  logic              sw_we_i,
  input  logic              sw_sel_data_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] sw_rdata_o
);
  logic [WORD_W-1:0] tag_q  [LINES];
  logic [WORD_W-1:0] data_q [LINES];

  assign look_tag_o  = tag_q[look_idx_i];
  assign look_data_o = data_q[look_idx_i];
  assign sw_rdata_o  = sw_sel_data_i ? data_q[sw_idx_i] : tag_q[sw_idx_i];

  // refill has priority; software writes are only enabled with caching off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (fill_i) begin
      tag_q[fill_idx_i] <= fill_tag_i;
    end else if (sw_we_i && !sw_sel_data_i) begin
      tag_q[sw_idx_i] <= sw_wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) data_q[fill_idx_i] <= fill_data_i;
    else if (sw_we_i && sw_sel_data_i) data_q[sw_idx_i] <= sw_wdata_i;
  end
endmodule

// File: rtl/icache_rgn_fetch.sv
module icache_rgn_fetch
  import icache_rgn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              hit_i,
  input  logic              cacheable_i,
  input  logic [WORD_W-1:0] line_data_i,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              fetch_valid_o,
  output logic [WORD_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fill_o,
  output logic [ADDR_W-1:0] fill_addr_o
);
  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fill_q;
  logic              valid_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      fill_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fetch_req_i) begin
          if (hit_i) begin
            valid_q <= 1'b1;
            data_q  <= line_data_i;
          end else begin
            st_q   <= ST_MISS;
            addr_q <= fetch_addr_i;
            fill_q <= cacheable_i;
          end
        end
        ST_MISS: if (mem_valid_i) begin
          st_q    <= ST_IDLE;
          valid_q <= 1'b1;
          data_q  <= mem_data_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o     = (st_q == ST_MISS);
  assign mem_addr_o    = addr_q & ~ADDR_W'(3);
  assign fill_o        = mem_req_o && mem_valid_i && fill_q;
  assign fill_addr_o   = addr_q;
  assign fetch_valid_o = valid_q;
  assign fetch_data_o  = data_q;
endmodule

// File: rtl/icache_rgn.sv
module icache_rgn
  import icache_rgn_pkg::*;
#(
  parameter int unsigned LINES = 256,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_LO = IDX_W + 2,
  localparam int unsigned WIN_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [31:0]       fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [31:0]       fetch_data_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_data_i,
  input  logic              cfg_we_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  input  logic              arr_req_i,
  input  logic              arr_we_i,
  input  logic [WIN_W-1:0]  arr_addr_i,
  input  logic [31:0]       arr_wdata_i,
  output logic [31:0]       arr_rdata_o
);
  logic [CFG_W-1:0]  ctrl_q;
  logic [CTRL_W-1:0] ctrl;
  logic              caching_off;
  logic              cacheable;
  logic              hit;
  logic [WORD_W-1:0] look_tag, look_data, sw_rdata, fill_tag;
  logic              fill;
  logic [ADDR_W-1:0] fill_addr;
  logic [WORD_W-1:0] arr_rdata_q;

  assign ctrl        = ctrl_q[CTRL_W-1:0];
  assign caching_off = (ctrl == '0);
  assign cfg_rdata_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (cfg_we_i) ctrl_q <= cfg_wdata_i & CTRL_MASK;
  end

  icache_rgn_dec u_dec (
    .addr_hi_i   (fetch_addr_i[ADDR_W-1:RGN_LO]),
    .ctrl_i      (ctrl),
    .cacheable_o (cacheable)
  );

  icache_rgn_arrays #(.LINES(LINES)) u_arr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .look_idx_i    (fetch_addr_i[TAG_LO-1:2]),
    .look_tag_o    (look_tag),
    .look_data_o   (look_data),
    .fill_i        (fill),
    .fill_idx_i    (fill_addr[TAG_LO-1:2]),
    .fill_tag_i    (fill_tag),
    .fill_data_i   (mem_data_i),
    .sw_we_i       (arr_req_i && arr_we_i && caching_off),
    .sw_sel_data_i (arr_addr_i[IDX_W]),
    .sw_idx_i      (arr_addr_i[IDX_W-1:0]),
    .sw_wdata_i    (arr_wdata_i),
    .sw_rdata_o    (sw_rdata)
  );

  assign hit = cacheable && look_tag[VALID_BIT]
            && (look_tag[CACHE_AW-1:TAG_LO] == fetch_addr_i[CACHE_AW-1:TAG_LO]);

  always_comb begin
    fill_tag                        = '0;
    fill_tag[VALID_BIT]             = 1'b1;
    fill_tag[CACHE_AW-1:TAG_LO]     = fill_addr[CACHE_AW-1:TAG_LO];
  end

  icache_rgn_fetch u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .hit_i         (hit),
    .cacheable_i   (cacheable),
    .line_data_i   (look_data),
    .mem_valid_i   (mem_valid_i),
    .mem_data_i    (mem_data_i),
    .fetch_valid_o (fetch_valid_o),
    .fetch_data_o  (fetch_data_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .fill_o        (fill),
    .fill_addr_o   (fill_addr)
  );

  // window reads see zero while any region is cached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arr_rdata_q <= '0;
    else if (arr_req_i && !arr_we_i) arr_rdata_q <= caching_off ? sw_rdata : '0;
  end
  assign arr_rdata_o = arr_rdata_q;
endmodule

// File: rtl/icache_rgn_chk.sv
module icache_rgn_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_req_i,
  input logic [31:0] fetch_addr_i,
  input logic        fetch_valid_o,
  input logic [31:0] fetch_data_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_valid_i,
  input logic [31:0] mem_data_i,
  input logic [15:0] cfg_rdata_o,
  input logic        arr_req_i,
  input logic        arr_we_i,
  input logic [31:0] arr_rdata_o
);
  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[15:5] == '0);

  // R5
  refill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R5
  refill_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> fetch_valid_o && fetch_data_o == $past(mem_data_i));

  // R4
  high_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && !mem_req_o && fetch_addr_i > 32'h01FF_FFFF |=> mem_req_o);

  // R12
  no_resp_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !fetch_valid_o);

  // R9
  win_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_i && !arr_we_i && cfg_rdata_o[4:0] != '0 |=> arr_rdata_o == '0);
endmodule

bind icache_rgn icache_rgn_chk u_chk (.*);

// File: tb/tb_icache_rgn.sv
module tb_icache_rgn;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [31:0] addr;
    logic        hit;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    {5'h1F, 32'h0000_0100, 1'b0},  // R1 cold miss
    {5'h1F, 32'h0000_0100, 1'b1},  // R6
    {5'h1F, 32'h0000_0500, 1'b0},  // R7 same index
    {5'h1F, 32'h0000_0100, 1'b0},  // R7 replaced
    {5'h1F, 32'h0000_0104, 1'b0},
    {5'h1F, 32'h0000_0104, 1'b1},
    {5'h1F, 32'h0200_0000, 1'b0},  // R4
    {5'h1F, 32'h0200_0000, 1'b0},  // R4 not filled
    {5'h1F, 32'h00C0_0010, 1'b0},  // R3 cs3
    {5'h1F, 32'h00C0_0010, 1'b1},
    {5'h1F, 32'h0100_0020, 1'b0},  // R3 dram
    {5'h1F, 32'h0100_0020, 1'b1},
    {5'h0F, 32'h0100_0020, 1'b0},  // R3 dram off, line valid
    {5'h0F, 32'h0100_0030, 1'b0},
    {5'h0F, 32'h0100_0030, 1'b0},  // R3 no fill
    {5'h1E, 32'h0000_0104, 1'b0},  // R3 cs0 off
    {5'h1E, 32'h0040_0104, 1'b0},  // cs1 fill
    {5'h1E, 32'h0040_0104, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_valid_o;
  logic [31:0] fetch_data_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        arr_req_i = 1'b0;
  logic        arr_we_i = 1'b0;
  logic [8:0]  arr_addr_i = '0;
  logic [31:0] arr_wdata_i = '0;
  logic [31:0] arr_rdata_o;

  int checks = 0;
  int errors = 0;

  icache_rgn dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return (a ^ 32'h5A5A_A5A5) + {a[15:0], 16'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic win_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    arr_req_i = 1'b1; arr_we_i = 1'b1; arr_addr_i = a; arr_wdata_i = d;
    @(negedge clk_i);
    arr_req_i = 1'b0; arr_we_i = 1'b0;
  endtask

  task automatic win_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk_i);
    arr_req_i = 1'b1; arr_we_i = 1'b0; arr_addr_i = a;
    @(negedge clk_i);
    arr_req_i = 1'b0;
    d = arr_rdata_o;
  endtask

  // fetch with immediate memory grant; checks hit/miss, address and data
  task automatic do_fetch(input logic [31:0] a, input bit exp_hit,
                          input logic [31:0] exp_data, input string req);
    bit got_hit;
    logic [31:0] got;
    @(negedge clk_i);
    fetch_req_i = 1'b1; fetch_addr_i = a;
    @(negedge clk_i);
    fetch_req_i = 1'b0;
    got_hit = fetch_valid_o;
    if (got_hit) begin
      got = fetch_data_o;
      chk(!mem_req_o, req, {31'b0, mem_req_o}, 32'h0);
    end else begin
      chk(mem_req_o && mem_addr_o == (a & ~32'h3), req, mem_addr_o, a & ~32'h3);
      mem_valid_i = 1'b1; mem_data_i = mem_model(a);
      @(negedge clk_i);
      mem_valid_i = 1'b0;
      chk(fetch_valid_o, req, {31'b0, fetch_valid_o}, 32'h1);
      got = fetch_data_o;
    end
    chk(got_hit == exp_hit, req, {31'b0, got_hit}, {31'b0, exp_hit});
    chk(got == exp_data, req, got, exp_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] rd;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!fetch_valid_o && !mem_req_o, "R1", {30'b0, fetch_valid_o, mem_req_o}, 32'h0);
    chk(cfg_rdata_o == 16'h0, "R1", {16'h0, cfg_rdata_o}, 32'h0);
    rst_ni = 1'b1;

    // R2 control register width
    cfg_write(16'hFFFF);
    chk(cfg_rdata_o == 16'h001F, "R2", {16'h0, cfg_rdata_o}, 32'h1F);

    // vector table: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      if (cfg_rdata_o[4:0] != VECS[i].ctrl) cfg_write({11'b0, VECS[i].ctrl});
      do_fetch(VECS[i].addr, VECS[i].hit, mem_model(VECS[i].addr), "R3/R4/R5/R6/R7 table");
    end

    // R8 R10 window view of a refilled line (index 0x41)
    cfg_write(16'h0);
    win_read(9'h041, rd);
    chk(rd == 32'h0240_0000, "R10 fill tag", rd, 32'h0240_0000);
    win_read(9'h141, rd);
    chk(rd == mem_model(32'h0040_0104), "R8 data read", rd, mem_model(32'h0040_0104));
    win_write(9'h1FF, 32'hDEAD_BEEF);
    win_read(9'h1FF, rd);
    chk(rd == 32'hDEAD_BEEF, "R8 data rw", rd, 32'hDEAD_BEEF);
    win_write(9'h0FF, 32'hFC00_03FF);
    win_read(9'h0FF, rd);
    chk(rd == 32'hFC00_03FF, "R8 tag rw all bits", rd, 32'hFC00_03FF);

    // R10 invalidate by clearing bit 25
    win_write(9'h041, 32'h0040_0000);
    cfg_write(16'h1F);
    do_fetch(32'h0040_0104, 1'b0, mem_model(32'h0040_0104), "R10 invalidate");

    // R11 preload line 0xFE with address 0x3F8
    cfg_write(16'h0);
    win_write(9'h0FE, 32'h0200_0000);
    win_write(9'h1FE, 32'h1234_5678);
    cfg_write(16'h1F);
    do_fetch(32'h0000_03F8, 1'b1, 32'h1234_5678, "R11 preload hit");

    // R9 window locked while caching enabled
    win_write(9'h1FE, 32'h0);
    win_read(9'h1FE, rd);
    chk(rd == 32'h0, "R9 read zero", rd, 32'h0);
    do_fetch(32'h0000_03F8, 1'b1, 32'h1234_5678, "R9 write ignored");

    // R12 request during outstanding refill
    @(negedge clk_i);
    fetch_req_i = 1'b1; fetch_addr_i = 32'h0000_0200;
    @(negedge clk_i);
    fetch_req_i = 1'b1; fetch_addr_i = 32'h0000_03F8;
    chk(mem_req_o && mem_addr_o == 32'h200, "R12 miss started", mem_addr_o, 32'h200);
    @(negedge clk_i);
    fetch_req_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(mem_req_o && !fetch_valid_o && mem_addr_o == 32'h200, "R12 busy", mem_addr_o, 32'h200);
      @(negedge clk_i);
    end
    mem_valid_i = 1'b1; mem_data_i = mem_model(32'h200);
    @(negedge clk_i);
    mem_valid_i = 1'b0;
    chk(fetch_valid_o && fetch_data_o == mem_model(32'h200), "R12 response", fetch_data_o, mem_model(32'h200));
    @(negedge clk_i);
    chk(!fetch_valid_o && !mem_req_o, "R12 single response", {30'b0, fetch_valid_o, mem_req_o}, 32'h0);

    finish_sim();
  end
endmodule